// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Link Endpoints

This block holds both ends of a point-to-point link that moves one data word at a time over dual-rail wire pairs and a single acknowledge wire. It is a clocked model of a return-to-zero handshake. Each data bit travels on its own pair of wires. A pair at 00 is the idle spacer. A pair at 01 carries a one and a pair at 10 carries a zero. The 11 code is never legal. No request wire exists: the receiver knows a word has arrived when every pair holds a legal data code.

The transmit end takes a word from a valid/ready interface and drives the encoded pairs. It holds them until the acknowledge comes back, then returns every pair to the spacer and waits for the acknowledge to fall. Only then does it take another word. The receive end brings the pairs into its clock domain through a synchronizer chain and waits for completion. It then hands the decoded word out as a one-cycle pulse and raises the acknowledge. It lowers the acknowledge once every pair reads spacer again.

The two ends meet only through the link wires, which leave and re-enter the block as ports. The surrounding logic routes them to the far end, so the link can cross a clock-domain boundary or a long wire. The acknowledge returning to the transmit end is synchronized in the same way.

Top module: `rz_dr_link`

## Requirements
- R1: `in_ready` is high exactly when the transmit end is idle. A word is taken only on a clock edge where `in_valid` and `in_ready` are both high.
- R2: On the edge that takes a word, `tx_rail` changes to the encoded word. Bit i of the word sits on `tx_rail[2i+1:2i]`: a one is driven as 01 (only `tx_rail[2i]` high) and a zero as 10 (only `tx_rail[2i+1]` high). The transmit end never drives 11 on a pair.
- R3: The transmit end holds the encoded word unchanged until it has seen `tx_ack_in` high through its two-stage synchronizer. On the next edge it drives every pair to 00.
- R4: After the spacer, the transmit end waits until it has seen `tx_ack_in` low through its synchronizer. Only then does it return to idle and raise `in_ready`.
- R5: The receive end samples `rx_rail` through a two-stage synchronizer. When every synchronized pair holds 01 or 10 and it is waiting for data, `out_valid` is high for exactly one cycle. `out_data` bit i then equals 1 for pair code 01 and 0 for pair code 10, and it holds that value until the next delivery.
- R6: `rx_ack_out` rises on the same edge that raises `out_valid`. It stays high until every synchronized pair reads 00, and falls on the next edge. No further word is delivered while it is high.
- R7: Any synchronized pair that reads 11 sets `protocol_error`, which stays high until reset. A set of pairs that contains 11 is never delivered as a word.
- R8: While `rst_n` is low, and on release, `in_ready` is 1. `tx_rail`, `rx_ack_out`, `out_valid`, `out_data` and `protocol_error` are all 0.
- R9: `in_valid` while the transmit end is busy has no effect. `tx_rail` keeps the word in flight, and the ignored word is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered to the transmit end |
| in_ready | output | 1 | Transmit end is idle and will take a word |
| in_data | input | WORD_W | Word offered for transfer |
| tx_rail | output | 2*WORD_W | Dual-rail pairs driven by the transmit end |
| tx_ack_in | input | 1 | Acknowledge arriving from the far receive end |
| rx_rail | input | 2*WORD_W | Dual-rail pairs arriving at the receive end |
| rx_ack_out | output | 1 | Acknowledge driven by the receive end |
| out_valid | output | 1 | One-cycle pulse: a word has been delivered |
| out_data | output | WORD_W | Most recently delivered word |
| protocol_error | output | 1 | Sticky flag: an illegal 11 pair has been seen |

## Verification
A transmit state stuck in the wrong phase shows up at the ports within one or two cycles. `tx_rail` leaves the held code early or late against the synchronized acknowledge, or `in_ready` comes back before the acknowledge has fallen. A receive end that mistracks completion or the spacer shows up as a missing or repeated `out_valid` pulse, or as an acknowledge edge off by a cycle, a few cycles after the rails change. Because the bench model tracks both ends every cycle, any of these shows up as a mismatch on that same cycle. Corrupting one pair to 11 checks that the error flag sets and stays set, and that no word is delivered until the pair recovers.

// File: rtl/rz_link_pkg.sv
package rz_link_pkg;

  localparam logic [1:0] CODE_SPACER = 2'b00;
  localparam logic [1:0] CODE_ONE    = 2'b01;
  localparam logic [1:0] CODE_ZERO   = 2'b10;
  localparam logic [1:0] CODE_BAD    = 2'b11;

  typedef enum logic [1:0] {
    TX_IDLE         = 2'd0,
    TX_DRIVE_VALID  = 2'd1,
    TX_DRIVE_SPACER = 2'd2,
    TX_WAIT_ACK_LOW = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_WAIT_DATA   = 1'b0,
    RX_WAIT_SPACER = 1'b1
  } rx_state_e;

  function automatic logic [1:0] encode_bit(input logic b);
    return b ? CODE_ONE : CODE_ZERO;
  endfunction

  function automatic logic decode_pair(input logic [1:0] pair);
    return pair == CODE_ONE;
  endfunction

  function automatic logic pair_is_spacer(input logic [1:0] pair);
    return pair == CODE_SPACER;
  endfunction

  function automatic logic pair_is_data(input logic [1:0] pair);
    return (pair == CODE_ONE) || (pair == CODE_ZERO);
  endfunction

  function automatic logic pair_is_bad(input logic [1:0] pair);
    return pair == CODE_BAD;
  endfunction

endpackage

// File: rtl/rz_sync.sv
module rz_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rz_tx.sv
module rz_tx
  import rz_link_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int RAIL_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              ack_seen,
  output logic [RAIL_W-1:0] rail,
  output logic              accept
);

  tx_state_e         state_q;
  logic [RAIL_W-1:0] rail_q;
  logic [RAIL_W-1:0] encoded;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_enc
      assign encoded[2*i+1:2*i] = encode_bit(in_data[i]);
    end
  endgenerate

  assign in_ready = (state_q == TX_IDLE);
  assign accept   = in_ready && in_valid;
  assign rail     = rail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      rail_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (accept) begin
            rail_q  <= encoded;
            state_q <= TX_DRIVE_VALID;
          end
        end
        TX_DRIVE_VALID: begin
          if (ack_seen) begin
            rail_q  <= '0;
            state_q <= TX_DRIVE_SPACER;
          end
        end
        TX_DRIVE_SPACER: begin
          state_q <= TX_WAIT_ACK_LOW;
        end
        TX_WAIT_ACK_LOW: begin
          if (!ack_seen) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rz_rx.sv
module rz_rx
  import rz_link_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int RAIL_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAIL_W-1:0] rail_seen,
  output logic              ack,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              protocol_error,
  output logic              complete,
  output logic              all_spacer,
  output logic              deliver
);

  rx_state_e         state_q;
  logic [WORD_W-1:0] pair_data;
  logic [WORD_W-1:0] pair_spacer;
  logic [WORD_W-1:0] pair_bad;
  logic [WORD_W-1:0] decoded;
  logic              any_bad;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_pair
      assign pair_data[i]   = pair_is_data(rail_seen[2*i+1:2*i]);
      assign pair_spacer[i] = pair_is_spacer(rail_seen[2*i+1:2*i]);
      assign pair_bad[i]    = pair_is_bad(rail_seen[2*i+1:2*i]);
      assign decoded[i]     = decode_pair(rail_seen[2*i+1:2*i]);
    end
  endgenerate

  assign complete   = &pair_data;
  assign all_spacer = &pair_spacer;
  assign any_bad    = |pair_bad;
  assign deliver    = (state_q == RX_WAIT_DATA) && complete;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= RX_WAIT_DATA;
      ack            <= 1'b0;
      out_valid      <= 1'b0;
      out_data       <= '0;
      protocol_error <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (any_bad) protocol_error <= 1'b1;
      unique case (state_q)
        RX_WAIT_DATA: begin
          if (deliver) begin
            out_data  <= decoded;
            out_valid <= 1'b1;
            ack       <= 1'b1;
            state_q   <= RX_WAIT_SPACER;
          end
        end
        RX_WAIT_SPACER: begin
          if (all_spacer) begin
            ack     <= 1'b0;
            state_q <= RX_WAIT_DATA;
          end
        end
        default: state_q <= RX_WAIT_DATA;
      endcase
    end
  end

endmodule

// File: rtl/rz_dr_link.sv
module rz_dr_link #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int RAIL_W     = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic [RAIL_W-1:0] tx_rail,
  input  logic              tx_ack_in,
  input  logic [RAIL_W-1:0] rx_rail,
  output logic              rx_ack_out,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              protocol_error
);

  logic              ack_seen;
  logic [RAIL_W-1:0] rail_seen;
  logic              tx_accept;
  logic              rx_complete;
  logic              rx_spacer;
  logic              rx_deliver;

  rz_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tx_ack_in),
    .q     (ack_seen)
  );

  rz_sync #(.WIDTH(RAIL_W), .STAGES(SYNC_STAGES)) u_rail_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_rail),
    .q     (rail_seen)
  );

  rz_tx #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .ack_seen (ack_seen),
    .rail     (tx_rail),
    .accept   (tx_accept)
  );

  rz_rx #(.WORD_W(WORD_W)) u_rx (
    .clk            (clk),
    .rst_n          (rst_n),
    .rail_seen      (rail_seen),
    .ack            (rx_ack_out),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .protocol_error (protocol_error),
    .complete       (rx_complete),
    .all_spacer     (rx_spacer),
    .deliver        (rx_deliver)
  );

endmodule

// File: rtl/rz_dr_link_chk.sv
module rz_dr_link_chk #(
  parameter int WORD_W = 8,
  localparam int RAIL_W = 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [RAIL_W-1:0] tx_rail,
  input logic              rx_ack_out,
  input logic              out_valid,
  input logic              protocol_error,
  input logic              ack_seen,
  input logic              tx_accept,
  input logic              rx_spacer,
  input logic              rx_deliver
);

  logic tx_has_bad;
  logic tx_all_data;

  always_comb begin
    tx_has_bad  = 1'b0;
    tx_all_data = 1'b1;
    for (int i = 0; i < WORD_W; i++) begin
      if (tx_rail[2*i] && tx_rail[2*i+1]) tx_has_bad = 1'b1;
      if (tx_rail[2*i] == tx_rail[2*i+1]) tx_all_data = 1'b0;
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (!in_ready && tx_all_data));

  // R2
  tx_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_has_bad);

  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_all_data && !ack_seen) |=> $stable(tx_rail));

  // R4
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R5
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_deliver |=> (out_valid && rx_ack_out));

  // R5
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack_out && !rx_spacer) |=> rx_ack_out);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);

endmodule

bind rz_dr_link rz_dr_link_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .tx_rail        (tx_rail),
  .rx_ack_out     (rx_ack_out),
  .out_valid      (out_valid),
  .protocol_error (protocol_error),
  .ack_seen       (ack_seen),
  .tx_accept      (tx_accept),
  .rx_spacer      (rx_spacer),
  .rx_deliver     (rx_deliver)
);

// File: tb/rz_dr_link_bench.sv
module rz_dr_link_bench;

  localparam int W = 8;
  localparam int RW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ready;
  logic [RW-1:0] tx_rail;
  logic [RW-1:0] rx_rail;
  logic [RW-1:0] fault_or = '0;
  logic          rx_ack_out;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          protocol_error;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign rx_rail = tx_rail | fault_or;

  rz_dr_link #(.WORD_W(W)) u_rz_dr_link (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .tx_rail (tx_rail), .tx_ack_in (rx_ack_out),
    .rx_rail (rx_rail), .rx_ack_out (rx_ack_out),
    .out_valid (out_valid), .out_data (out_data),
    .protocol_error (protocol_error)
  );

  function automatic logic [RW-1:0] dual_of(input logic [W-1:0] w);
    logic [RW-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[2*i]   = w[i];
      r[2*i+1] = !w[i];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            m_tx;        // 0 idle, 1 valid, 2 spacer, 3 wait ack low
  logic [RW-1:0] m_rail;
  int            m_rx;        // 0 wait data, 1 wait spacer
  bit            m_ack, m_ov, m_err;
  logic [W-1:0]  m_data;
  bit            a1, a2;
  logic [RW-1:0] r1, r2;
  logic [W-1:0]  sent_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rail = '0; m_rx = 0; m_ack = 0; m_ov = 0; m_err = 0;
      m_data = '0; a1 = 0; a2 = 0; r1 = '0; r2 = '0;
    end else begin
      bit all_dat, all_sp, bad;
      all_dat = 1; all_sp = 1; bad = 0;
      for (int i = 0; i < W; i++) begin
        if (r2[2*i] == r2[2*i+1]) all_dat = 0;
        if (r2[2*i] || r2[2*i+1]) all_sp = 0;
        if (r2[2*i] && r2[2*i+1]) bad = 1;
      end
      case (m_tx)
        0: if (in_valid) begin m_rail = dual_of(in_data); m_tx = 1; sent_q.push_back(in_data); end
        1: if (a2) begin m_rail = '0; m_tx = 2; end
        2: m_tx = 3;
        default: if (!a2) m_tx = 0;
      endcase
      m_ov = 0;
      if (bad) m_err = 1;
      if (m_rx == 0) begin
        if (all_dat) begin
          for (int i = 0; i < W; i++) m_data[i] = r2[2*i];
          m_ov = 1; m_ack = 1; m_rx = 1;
        end
      end else if (all_sp) begin
        m_ack = 0; m_rx = 0;
      end
      a2 = a1; a1 = rx_ack_out;
      r2 = r1; r1 = rx_rail;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(in_ready == (m_tx == 0), "R1", "in_ready", in_ready, m_tx == 0);
      check(tx_rail == m_rail, "R2/R3", "tx_rail", tx_rail, m_rail);
      check(rx_ack_out == m_ack, "R6", "rx_ack_out", rx_ack_out, m_ack);
      check(out_valid == m_ov, "R5", "out_valid", out_valid, m_ov);
      check(out_data == m_data, "R5", "out_data", out_data, m_data);
      check(protocol_error == m_err, "R7", "protocol_error", protocol_error, m_err);
      if (out_valid && rst_n) begin
        logic [W-1:0] e;
        e = (sent_q.size() > 0) ? sent_q.pop_front() : 'x;
        check(out_data === e, "R5", "end-to-end word", out_data, e);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [W-1:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    for (int n = 0; n < 200 && !in_ready; n++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (in_ready && !rx_ack_out) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset values while held
    check(in_ready == 1 && tx_rail == 0 && rx_ack_out == 0 && out_valid == 0 &&
          out_data == 0 && protocol_error == 0, "R8", "reset state",
          {in_ready, rx_ack_out, out_valid, protocol_error}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1 && tx_rail == 0, "R8", "after release", in_ready, 1);

    send(8'hA5); wait_idle();
    send(8'h00); wait_idle();
    send(8'hFF); wait_idle();

    // R9: offer a word while busy; it must not disturb the flight
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h3C;
    @(negedge clk);
    in_data = 8'h77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(tx_rail == dual_of(8'h3C), "R9", "rail held while busy", tx_rail, dual_of(8'h3C));
      check(!in_ready, "R9", "busy not ready", in_ready, 0);
    end
    in_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(sent_q.size() == 0, "R9", "no extra word queued", sent_q.size(), 0);

    // back-to-back with in_valid held high
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A;
    for (int n = 0; n < 100 && !in_ready; n++) @(negedge clk);
    @(negedge clk);
    in_data = 8'h81;
    for (int n = 0; n < 100 && !in_ready; n++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R7: illegal 11 on pair 0 while idle, then send a word
    fault_or = {{(RW-2){1'b0}}, 2'b11};
    repeat (4) @(negedge clk);
    check(protocol_error == 1, "R7", "error raised", protocol_error, 1);
    send(8'hC3);
    repeat (20) @(negedge clk);
    check(!in_ready, "R7", "bad word not completed", in_ready, 0);
    fault_or = '0;
    wait_idle();
    check(protocol_error == 1, "R7", "error sticky", protocol_error, 1);
    send(8'h42); wait_idle();
    repeat (4) @(negedge clk);
    check(sent_q.size() == 0, "R5", "all words delivered", sent_q.size(), 0);

    finish_run();
  end

endmodule